// File: doc/BRIEF.md
# Constant-Time Modular Adder/Subtractor

This block returns either the modular sum or the modular difference of two field elements that are smaller than an odd modulus of up to `DATA_W` bits. It works one `DIGIT_W`-bit digit per clock on operand shift registers that are `DATA_W + DIGIT_W` bits wide, and it holds the carry between digits in a flip-flop. A run has two full passes over every digit. The first pass forms the plain integer sum or difference. The second pass always applies the modulus correction to that intermediate value, subtracting the modulus after an add and adding it back after a subtract. Both candidates are kept in scratch registers. At the end, a flag taken from the carry out of one pass picks the result.

Because the correction pass runs on every request, the cycle count is the same for every operand value and for both operations. The same holds for the number of digit operations and the pattern of register writes. This hides from simple power analysis whether a reduction was needed. The price is extra latency. The block is started by a one-cycle `start` pulse while idle. It samples all inputs on that edge and pulses `done` when `result` is valid.

Top module: `modaddsub_ct`

## Requirements
- R1: While reset is active and on the first cycle after it, `done` and `busy` are 0 and `result` is 0.
- R2: With `op_sub` = 0 at start and `a_in`, `b_in` < `p_in`, the `result` shown with `done` equals (a + b) mod p.
- R3: With `op_sub` = 1 at start and `a_in`, `b_in` < `p_in`, the `result` shown with `done` equals (a − b) mod p, wrapping to a − b + p when b > a.
- R4: `done` rises exactly 2·ND + 1 clock edges after the edge that accepts `start`, where ND = (DATA_W + DIGIT_W) / DIGIT_W. This is 35 with the defaults, for every operand value and for both operations.
- R5: Every run performs both passes in order: ND digit steps of the first pass, then ND digit steps of the correction pass, then the selection cycle. `busy` is therefore high for exactly 2·ND + 1 cycles (35 with the defaults).
- R6: A `start` pulse while `busy` is high is ignored. The running operation keeps its operation, its operands, its result and its timing, and no second run follows.
- R7: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R8: `result` changes only in the cycle where `done` is high and holds its value until the next `done`.
- R9: `op_sub`, `a_in`, `b_in` and `p_in` are sampled only on the edge that accepts `start`; changing them during a run has no effect on its result.
- R10: Boundary values reduce correctly: a sum equal to p gives 0, a difference of equal operands gives 0, 0 − (p−1) gives 1, and (p−1)+(p−1) with p close to 2^DATA_W gives p−2 even though the raw sum overflows DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| op_sub | input | 1 | 0 selects modular add, 1 selects modular subtract |
| a_in | input | DATA_W | First operand, less than the modulus |
| b_in | input | DATA_W | Second operand, less than the modulus |
| p_in | input | DATA_W | Modulus |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | DATA_W | Reduced sum or difference |

## Verification
The hardest behaviour to reach from the ports is a carry that crosses the operand width. A sum must carry into the extra guard digit, and the correction must then borrow back across every digit. The bench reaches this with a modulus just below 2^DATA_W and both operands equal to p−1. It also checks a sum that lands exactly on p, where the second pass produces zero with no borrow, and subtractions whose borrow ripples through every digit. A start pulse in the middle of a run and inputs that are inverted every cycle show that only the accepted request shapes the result.

// File: rtl/modaddsub_pkg.sv
package modaddsub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_PICK   = 2'd3
  } mas_state_e;

  // Carry flags are "no borrow" for subtract passes.
  // Add: pass two subtracted p; keep it when it did not borrow.
  // Sub: pass two added p; keep it when pass one borrowed.
  function automatic logic take_second(input logic is_sub,
                                       input logic c_first,
                                       input logic c_second);
    return is_sub ? ~c_first : c_second;
  endfunction

endpackage

// File: rtl/mas_digit_alu.sv
module mas_digit_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic logic [W:0] digit_step(input logic [W-1:0] xa,
                                            input logic [W-1:0] ya,
                                            input logic         ci,
                                            input logic         is_sub);
    logic [W-1:0] yy;
    yy = is_sub ? ~ya : ya;
    return {1'b0, xa} + {1'b0, yy} + {{W{1'b0}}, ci};
  endfunction

  logic [W:0] wide;
  assign wide = digit_step(x, y, cin, sub);
  assign sum  = wide[W-1:0];
  assign cout = wide[W];

endmodule

// File: rtl/mas_shreg.sv
module mas_shreg #(
  parameter int WIDTH = 272,
  parameter int STEP  = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic [STEP-1:0]  fill,
  output logic [OUT_W-1:0] out
);

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= {fill, q[WIDTH-1:STEP]};
    end
  end

  assign out = q[OUT_W-1:0];

endmodule

// File: rtl/mas_ctrl.sv
module mas_ctrl
  import modaddsub_pkg::*;
#(
  parameter int NDIG = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_go,
  output logic first_act,
  output logic second_act,
  output logic digit_last,
  output logic pick_now,
  output logic busy
);

  localparam int CW = (NDIG > 1) ? $clog2(NDIG) : 1;

  mas_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign digit_last = (cnt_q == CW'(NDIG - 1));
  assign load_go    = (state_q == ST_IDLE) && start;
  assign first_act  = (state_q == ST_FIRST);
  assign second_act = (state_q == ST_SECOND);
  assign pick_now   = (state_q == ST_PICK);
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= ST_FIRST;
        end
        ST_FIRST: begin
          if (digit_last) begin
            cnt_q   <= '0;
            state_q <= ST_SECOND;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_SECOND: begin
          if (digit_last) begin
            cnt_q   <= '0;
            state_q <= ST_PICK;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/modaddsub_ct.sv
module modaddsub_ct
  import modaddsub_pkg::*;
#(
  parameter int DATA_W  = 256,
  parameter int DIGIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] p_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  localparam int OPW  = DATA_W + DIGIT_W;
  localparam int NDIG = OPW / DIGIT_W;
  localparam int NOPD = 3;

  // Named internal events
  logic load_go, first_act, second_act, digit_last, pick_now;
  logic alu_active;

  logic op_q, carry_q, c1_q, c2_q, done_q;
  logic [DATA_W-1:0] result_q;

  mas_ctrl #(.NDIG(NDIG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .load_go    (load_go),
    .first_act  (first_act),
    .second_act (second_act),
    .digit_last (digit_last),
    .pick_now   (pick_now),
    .busy       (busy)
  );

  assign alu_active = first_act | second_act;

  // Operand registers: 0 = a, 1 = b, 2 = modulus
  logic [OPW-1:0]     opnd_ld [NOPD];
  logic               opnd_sh [NOPD];
  logic [DIGIT_W-1:0] opnd_lo [NOPD];

  assign opnd_ld[0] = {{DIGIT_W{1'b0}}, a_in};
  assign opnd_ld[1] = {{DIGIT_W{1'b0}}, b_in};
  assign opnd_ld[2] = {{DIGIT_W{1'b0}}, p_in};
  assign opnd_sh[0] = first_act;
  assign opnd_sh[1] = first_act;
  assign opnd_sh[2] = second_act;

  for (genvar gi = 0; gi < NOPD; gi++) begin : g_opnd
    mas_shreg #(.WIDTH(OPW), .STEP(DIGIT_W), .OUT_W(DIGIT_W)) u_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_go),
      .load_val (opnd_ld[gi]),
      .shift    (opnd_sh[gi]),
      .fill     ({DIGIT_W{1'b0}}),
      .out      (opnd_lo[gi])
    );
  end

  // Digit adder/subtractor shared by both passes
  logic [DIGIT_W-1:0] alu_x, alu_y, alu_sum;
  logic               alu_sub, alu_cout;
  logic [DATA_W-1:0]  s1_out, s2_out;

  assign alu_x   = second_act ? s1_out[DIGIT_W-1:0] : opnd_lo[0];
  assign alu_y   = second_act ? opnd_lo[2] : opnd_lo[1];
  assign alu_sub = second_act ? ~op_q : op_q;

  mas_digit_alu #(.W(DIGIT_W)) u_alu (
    .x    (alu_x),
    .y    (alu_y),
    .cin  (carry_q),
    .sub  (alu_sub),
    .sum  (alu_sum),
    .cout (alu_cout)
  );

  // Scratch: pass-one value (rotated during pass two) and pass-two value
  logic [DIGIT_W-1:0] s1_fill;
  assign s1_fill = first_act ? alu_sum : s1_out[DIGIT_W-1:0];

  mas_shreg #(.WIDTH(OPW), .STEP(DIGIT_W), .OUT_W(DATA_W)) u_scratch1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val ({OPW{1'b0}}),
    .shift    (alu_active),
    .fill     (s1_fill),
    .out      (s1_out)
  );

  mas_shreg #(.WIDTH(OPW), .STEP(DIGIT_W), .OUT_W(DATA_W)) u_scratch2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val ({OPW{1'b0}}),
    .shift    (second_act),
    .fill     (alu_sum),
    .out      (s2_out)
  );

  // Carry chain and pass flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      carry_q <= 1'b0;
      c1_q    <= 1'b0;
      c2_q    <= 1'b0;
    end else if (load_go) begin
      op_q    <= op_sub;
      carry_q <= op_sub;
    end else if (first_act && digit_last) begin
      c1_q    <= alu_cout;
      carry_q <= ~op_q;
    end else if (second_act && digit_last) begin
      c2_q    <= alu_cout;
      carry_q <= alu_cout;
    end else if (alu_active) begin
      carry_q <= alu_cout;
    end
  end

  logic sel_second;
  assign sel_second = take_second(op_q, c1_q, c2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= pick_now;
      if (pick_now) result_q <= sel_second ? s2_out : s1_out;
    end
  end

  assign done   = done_q;
  assign result = result_q;

endmodule

// File: rtl/modaddsub_chk.sv
module modaddsub_chk #(
  parameter int DATA_W = 256,
  parameter int NDIG   = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              op_q,
  input logic              first_act,
  input logic              second_act,
  input logic              digit_last,
  input logic              pick_now
);

  localparam int ACW = $clog2(2 * NDIG + 1);

  logic [ACW-1:0] act_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_cnt <= '0;
    else if (start && !busy) act_cnt <= '0;
    else if (first_act || second_act) act_cnt <= act_cnt + ACW'(1);
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  pick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_now |=> done);

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({first_act, second_act, pick_now}));

  // R5
  pass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_act && digit_last) |=> second_act);

  // R5
  pass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_now |-> (act_cnt == ACW'(2 * NDIG)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R6
  op_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

endmodule

bind modaddsub_ct modaddsub_chk #(.DATA_W(DATA_W), .NDIG(NDIG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .op_q       (op_q),
  .first_act  (first_act),
  .second_act (second_act),
  .digit_last (digit_last),
  .pick_now   (pick_now)
);

// File: tb/modaddsub_ct_bench.sv
module modaddsub_ct_bench;

  localparam int CLK_P = 10;
  localparam int DW    = 256;
  localparam int ND    = (DW + 16) / 16;
  localparam int LAT   = 2 * ND + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_sub = 1'b0;
  logic [DW-1:0] a_in = '0, b_in = '0, p_in = '0;
  logic          busy, done;
  logic [DW-1:0] result;

  int total = 0;
  int fails = 0;

  always #(CLK_P / 2) clk = ~clk;

  modaddsub_ct u_modaddsub_ct (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_in(a_in), .b_in(b_in), .p_in(p_in),
    .busy(busy), .done(done), .result(result)
  );

  localparam logic [DW-1:0] P_A = 256'hFFFFFFFF00000001000000000000000000000000FFFFFFFFFFFFFFFFFFFFFFFF;
  localparam logic [DW-1:0] P_B = {DW{1'b1}} - 256'd188;
  localparam logic [DW-1:0] P_C = 256'd1000003;

  function automatic logic [DW-1:0] ref_mod(input logic op, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b, input logic [DW-1:0] p);
    logic [DW+1:0] t;
    if (!op) begin
      t = {2'b00, a} + {2'b00, b};
      if (t >= {2'b00, p}) t = t - {2'b00, p};
    end else if (a >= b) begin
      t = {2'b00, a} - {2'b00, b};
    end else begin
      t = {2'b00, a} + {2'b00, p} - {2'b00, b};
    end
    return t[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 inputs toggled every cycle, 2 start pulsed mid-run
  task automatic launch(input logic op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [DW-1:0] p, input int mode,
                        output int lat, output int bcnt);
    @(negedge clk);
    op_sub = op; a_in = a; b_in = b; p_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    bcnt = busy ? 1 : 0;
    while (!done && lat < 200) begin
      if (mode == 1) begin
        a_in = ~a_in; b_in = ~b_in; p_in = ~p_in; op_sub = ~op_sub;
      end
      if (mode == 2 && lat == 10) begin
        start = 1'b1; op_sub = ~op; a_in = b; b_in = a; p_in = P_C;
      end
      if (mode == 2 && lat == 11) start = 1'b0;
      @(negedge clk);
      lat++;
      if (busy) bcnt++;
    end
  endtask

  task automatic run_op(input string req, input logic op, input logic [DW-1:0] a,
                        input logic [DW-1:0] b, input logic [DW-1:0] p, input int mode);
    int lat, bcnt;
    logic [DW-1:0] exp;
    exp = ref_mod(op, a, b, p);
    launch(op, a, b, p, mode, lat, bcnt);
    chk(lat == LAT, "R4 latency", DW'(lat), DW'(LAT));
    chk(result == exp, req, result, exp);
    chk(bcnt == LAT, "R5 busy cycles", DW'(bcnt), DW'(LAT));
    chk(busy == 1'b0, "R7 busy in done cycle", DW'(busy), '0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done width", DW'(done), '0);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done", DW'(done), '0);
    chk(busy == 1'b0, "R1 busy", DW'(busy), '0);
    chk(result == '0, "R1 result", result, '0);
  endtask

  task automatic t_add();
    run_op("R2 add wraps", 1'b0, P_A - 256'd5, 256'h1234_5678_9abc_def0_1111_2222, P_A, 0);
    run_op("R2 add no wrap", 1'b0, 256'h0123_4567_89ab_cdef_0000_ffff_0000_ffff, 256'd77, P_A, 0);
    run_op("R2 small modulus", 1'b0, 256'd999999, 256'd12345, P_C, 0);
  endtask

  task automatic t_sub();
    run_op("R3 sub a>b", 1'b1, P_A - 256'd3, 256'hdead_beef_cafe_f00d, P_A, 0);
    run_op("R3 sub a<b", 1'b1, 256'd42, P_A - 256'd1000, P_A, 0);
    run_op("R3 small modulus", 1'b1, 256'd5, 256'd1000000, P_C, 0);
  endtask

  task automatic t_edges();
    run_op("R10 sum equals p", 1'b0, 256'h8000_0000_1234, P_A - 256'h8000_0000_1234, P_A, 0);
    run_op("R10 equal operands", 1'b1, 256'h5555_aaaa_5555, 256'h5555_aaaa_5555, P_A, 0);
    run_op("R10 zero minus p-1", 1'b1, 256'd0, P_B - 256'd1, P_B, 0);
    run_op("R10 overflow add", 1'b0, P_B - 256'd1, P_B - 256'd1, P_B, 0);
  endtask

  task automatic t_busy_start();
    run_op("R6 start while busy", 1'b0, P_A - 256'd9, P_A - 256'd11, P_A, 2);
    for (int i = 0; i < 5; i++) begin
      chk(done == 1'b0 && busy == 1'b0, "R6 no second run", DW'({busy, done}), '0);
      @(negedge clk);
    end
  endtask

  task automatic t_input_change();
    run_op("R9 inputs toggled", 1'b1, 256'd17, 256'hffff_0000_ffff, P_A, 1);
  endtask

  task automatic t_hold();
    logic [DW-1:0] kept;
    run_op("R8 setup", 1'b0, 256'd300, 256'd400, P_A, 0);
    kept = result;
    for (int i = 0; i < 8; i++) begin
      a_in = ~a_in; b_in = b_in + 256'd1; op_sub = ~op_sub;
      @(negedge clk);
      chk(result == kept && done == 1'b0, "R8 result held", result, kept);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; fails++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_edges();
    t_busy_start();
    t_input_change();
    t_hold();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule